// File: doc/BRIEF.md
# Double-Buffered 8-bit PWM Compare Module

This block drives one pulse-width-modulated output from a free-running timer. The timer advances one step on each pulse of a chosen tick source, and one PWM period spans every timer value. Within a period the output is low while the timer is below the active compare byte and high from that point to the end of the period. A larger compare byte therefore gives a shorter high time. A compare byte of zero keeps the output high all the time.

The block has a second byte, the shadow byte. Software writes the duty for the next period into the shadow byte. When the timer wraps from its top value to zero, the shadow byte is copied into the active compare byte, so the duty changes only at a period boundary. Software can also write the active byte directly, and that write takes effect at once.

The block works only when both mode bits are set. While either mode bit is clear, the timer and both bytes are held at zero and the output stays high. The timer steps only while the run input is high.

Top module: `pwm_cmp_top`

## Requirements
- R1: While `rst_ni` is low, `pwm_o` is high, and the timer and both bytes are zero. After reset is released with both mode bits set and run high, and with no write, the output stays high for a whole period.
- R2: PWM mode is on only when `cmp_en_i` and `pwm_en_i` are both 1. In any other case `pwm_o` is high, the timer and both bytes are cleared to zero, and writes to either byte have no effect.
- R3: In PWM mode, `pwm_o` is 0 while timer < active byte and 1 while timer >= active byte. Over one period the output is high for 256 - active ticks: 256 ticks (always high) for 0, and 1 tick for 255.
- R4: The timer moves up by one on each selected tick while `run_i` is 1, and it does not move while `run_i` is 0. One period is 256 ticks.
- R5: When `wr_act_i` is 1 and no wrap happens in that cycle, the active byte takes `wr_data_i` at the next clock edge, and the output follows in the next cycle.
- R6: When `wr_shd_i` is 1, only the shadow byte takes `wr_data_i`. The active byte takes the shadow value only on the tick where the timer goes from 255 to 0.
- R7: If a wrap and a write to the active byte happen in the same cycle, the active byte takes the old shadow value. A shadow write in that same cycle still loads the shadow byte.
- R8: The value of `src_sel_i` picks the tick source: 0 is the clock divided by 4, 1 is the clock divided by 12, 2 is a rising edge on `ext_tick_i`, and 3 is a pulse on `ovf_tick_i`, where each cycle with `ovf_tick_i` high counts as one tick.
- R9: With source 2, `ext_tick_i` passes through a two-stage synchronizer. Each rising edge gives exactly one tick, and an input held at one level gives no ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low, released synchronously inside the block |
| src_sel_i | input | 2 | Tick source select (see R8) |
| ext_tick_i | input | 1 | External tick input; each rising edge is one tick |
| ovf_tick_i | input | 1 | Overflow pulse from another timer; one tick for each cycle it is high |
| run_i | input | 1 | Timer run control |
| cmp_en_i | input | 1 | Compare-enable mode bit |
| pwm_en_i | input | 1 | PWM-enable mode bit |
| wr_act_i | input | 1 | Write strobe for the active compare byte |
| wr_shd_i | input | 1 | Write strobe for the shadow byte |
| wr_data_i | input | 8 | Write data for both strobes |
| pwm_o | output | 1 | PWM output |

## Verification
A wrong timer value shows up on `pwm_o` in the same cycle, because the output is the timer compared with the active byte, with no register in between. Tests that step the timer one tick at a time find an error on the first tick where the timer crosses the compare value. A wrong active byte changes the number of high ticks in the period that follows.

An active byte loaded early from the shadow byte, or a copy that never happens, hides for the rest of the current period. It is caught by counting the high ticks over two periods back to back. A lost wrap-collision priority only becomes visible when the timer reaches the value that tells the two candidate bytes apart.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  typedef enum logic [1:0] {
    SRC_CLK_DIV_A = 2'd0,
    SRC_CLK_DIV_B = 2'd1,
    SRC_EXT_EDGE  = 2'd2,
    SRC_OVF_PULSE = 2'd3
  } tick_src_e;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_cmp_pkg::*;
#(
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] src_sel_i,
  input  logic       ext_tick_i,
  input  logic       ovf_tick_i,
  output logic       tick_o
);
  localparam int AW = (DIV_A > 1) ? $clog2(DIV_A) : 1;
  localparam int BW = (DIV_B > 1) ? $clog2(DIV_B) : 1;
  localparam logic [AW-1:0] A_LAST = AW'(DIV_A - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DIV_B - 1);

  logic [AW-1:0] div_a_q, div_a_d;
  logic [BW-1:0] div_b_q, div_b_d;
  logic          tick_a, tick_b;

  logic [SYNC_STAGES-1:0] ext_sync_q, ext_sync_d;
  logic                   ext_prev_q;
  logic                   ext_rise;

  // Next-state logic for the two free-running dividers
  always_comb begin
    tick_a  = (div_a_q == A_LAST);
    tick_b  = (div_b_q == B_LAST);
    div_a_d = tick_a ? '0 : div_a_q + 1'b1;
    div_b_d = tick_b ? '0 : div_b_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_a_q <= '0;
      div_b_q <= '0;
    end else begin
      div_a_q <= div_a_d;
      div_b_q <= div_b_d;
    end
  end

  // External input: synchronizer chain and rising-edge detect
  always_comb begin
    ext_sync_d = {ext_sync_q[SYNC_STAGES-2:0], ext_tick_i};
    ext_rise   = ext_sync_q[SYNC_STAGES-1] & ~ext_prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_sync_q <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      ext_sync_q <= ext_sync_d;
      ext_prev_q <= ext_sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    unique case (tick_src_e'(src_sel_i))
      SRC_CLK_DIV_A: tick_o = tick_a;
      SRC_CLK_DIV_B: tick_o = tick_b;
      SRC_EXT_EDGE:  tick_o = ext_rise;
      SRC_OVF_PULSE: tick_o = ovf_tick_i;
      default:       tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (adv_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = adv_i & ~clr_i & (cnt_q == TOP);
endmodule

// File: rtl/pwm_duty_regs.sv
module pwm_duty_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wrap_i,
  input  logic             wr_act_i,
  input  logic             wr_shd_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] act_o,
  output logic [WIDTH-1:0] shd_o
);
  logic [WIDTH-1:0] act_q, act_d;
  logic [WIDTH-1:0] shd_q, shd_d;

  // A wrap copy takes priority over a direct write to the active byte
  always_comb begin
    act_d = act_q;
    shd_d = shd_q;
    if (clr_i) begin
      act_d = '0;
      shd_d = '0;
    end else begin
      if (wrap_i)        act_d = shd_q;
      else if (wr_act_i) act_d = wr_data_i;
      if (wr_shd_i)      shd_d = wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      shd_q <= '0;
    end else begin
      act_q <= act_d;
      shd_q <= shd_d;
    end
  end

  assign act_o = act_q;
  assign shd_o = shd_q;
endmodule

// File: rtl/pwm_cmp_top.sv
module pwm_cmp_top #(
  parameter int WIDTH       = 8,
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       src_sel_i,
  input  logic             ext_tick_i,
  input  logic             ovf_tick_i,
  input  logic             run_i,
  input  logic             cmp_en_i,
  input  logic             pwm_en_i,
  input  logic             wr_act_i,
  input  logic             wr_shd_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic             pwm_o
);
  logic             rst_sync_n;
  logic             tick;
  logic             mode_en;
  logic             adv;
  logic             wrap;
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] act_byte;
  logic [WIDTH-1:0] shd_byte;

  pwm_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  pwm_tick_gen #(
    .DIV_A       (DIV_A),
    .DIV_B       (DIV_B),
    .SYNC_STAGES (SYNC_STAGES)
  ) tick_gen_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .src_sel_i  (src_sel_i),
    .ext_tick_i (ext_tick_i),
    .ovf_tick_i (ovf_tick_i),
    .tick_o     (tick)
  );

  assign mode_en = cmp_en_i & pwm_en_i;
  assign adv     = mode_en & run_i & tick;

  pwm_timer #(.WIDTH(WIDTH)) timer_i (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .clr_i  (~mode_en),
    .adv_i  (adv),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  pwm_duty_regs #(.WIDTH(WIDTH)) duty_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .clr_i     (~mode_en),
    .wrap_i    (wrap),
    .wr_act_i  (wr_act_i),
    .wr_shd_i  (wr_shd_i),
    .wr_data_i (wr_data_i),
    .act_o     (act_byte),
    .shd_o     (shd_byte)
  );

  assign pwm_o = ~mode_en | (cnt >= act_byte);
endmodule

// File: rtl/pwm_cmp_chk.sv
module pwm_cmp_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             mode_en,
  input logic             adv,
  input logic             wrap,
  input logic [WIDTH-1:0] cnt,
  input logic [WIDTH-1:0] act_byte,
  input logic [WIDTH-1:0] shd_byte,
  input logic             wr_act_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic             pwm_o
);
  assert_off_high_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !mode_en |-> pwm_o);

  assert_off_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !mode_en |=> (cnt == '0 && act_byte == '0 && shd_byte == '0));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_en && !adv) |=> $stable(cnt));

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_en && adv) |=> cnt == WIDTH'($past(cnt) + 1'b1));

  assert_act_write_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_en && wr_act_i && !wrap) |=> act_byte == $past(wr_data_i));

  assert_wrap_copy_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_en && wrap) |=> act_byte == $past(shd_byte));

  assert_zero_high_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_en && act_byte == '0) |-> pwm_o);
endmodule

bind pwm_cmp_top pwm_cmp_chk #(.WIDTH(WIDTH)) chk_i (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .mode_en   (mode_en),
  .adv       (adv),
  .wrap      (wrap),
  .cnt       (cnt),
  .act_byte  (act_byte),
  .shd_byte  (shd_byte),
  .wr_act_i  (wr_act_i),
  .wr_data_i (wr_data_i),
  .pwm_o     (pwm_o)
);

// File: tb/pwm_cmp_top_tb_top.sv
module pwm_cmp_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [1:0] src_sel_i;
  logic       ext_tick_i;
  logic       ovf_tick_i;
  logic       run_i;
  logic       cmp_en_i;
  logic       pwm_en_i;
  logic       wr_act_i;
  logic       wr_shd_i;
  logic [7:0] wr_data_i;
  logic       pwm_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pwm_cmp_top dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_sel_i  (src_sel_i),
    .ext_tick_i (ext_tick_i),
    .ovf_tick_i (ovf_tick_i),
    .run_i      (run_i),
    .cmp_en_i   (cmp_en_i),
    .pwm_en_i   (pwm_en_i),
    .wr_act_i   (wr_act_i),
    .wr_shd_i   (wr_shd_i),
    .wr_data_i  (wr_data_i),
    .pwm_o      (pwm_o)
  );

  // Each entry: {duty byte, expected high ticks per period}
  localparam logic [16:0] VEC_TBL [8] = '{
    {8'd0,   9'd256}, {8'd1,   9'd255}, {8'd25,  9'd231}, {8'd128, 9'd128},
    {8'd200, 9'd56},  {8'd230, 9'd26},  {8'd254, 9'd2},   {8'd255, 9'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    ovf_tick_i = 1'b1;
    @(negedge clk_i);
    ovf_tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic write(input logic act, input logic shd, input logic [7:0] d);
    wr_act_i  = act;
    wr_shd_i  = shd;
    wr_data_i = d;
    @(negedge clk_i);
    wr_act_i  = 1'b0;
    wr_shd_i  = 1'b0;
  endtask

  task automatic period_highs(output int highs);
    highs = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwm_o) highs++;
      tick();
    end
  endtask

  task automatic clk_highs(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_o) highs++;
      @(negedge clk_i);
    end
  endtask

  // Clear the block through the mode bits, then enable with run low
  task automatic setup(input logic [1:0] src);
    run_i    = 1'b0;
    cmp_en_i = 1'b0;
    pwm_en_i = 1'b0;
    @(negedge clk_i);
    src_sel_i = src;
    cmp_en_i  = 1'b1;
    pwm_en_i  = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int h;
    rst_ni     = 1'b0;
    src_sel_i  = 2'd3;
    ext_tick_i = 1'b0;
    ovf_tick_i = 1'b0;
    run_i      = 1'b1;
    cmp_en_i   = 1'b1;
    pwm_en_i   = 1'b1;
    wr_act_i   = 1'b0;
    wr_shd_i   = 1'b0;
    wr_data_i  = 8'd0;
    repeat (3) @(negedge clk_i);
    check("R1 output high in reset", int'(pwm_o), 1);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    period_highs(h);
    check("R1 cleared bytes give full-high period", h, 256);

    // Table of duty vectors, overflow-pulse source (R3, R8 code 3)
    for (int v = 0; v < 8; v++) begin
      setup(2'd3);
      write(1'b1, 1'b1, VEC_TBL[v][16:9]);
      run_i = 1'b1;
      period_highs(h);
      check($sformatf("R3 duty %0d high ticks", VEC_TBL[v][16:9]), h, int'(VEC_TBL[v][8:0]));
    end

    // Shadow deferral and rollover copy (R6)
    setup(2'd3);
    write(1'b1, 1'b0, 8'd0);
    write(1'b0, 1'b1, 8'd128);
    run_i = 1'b1;
    period_highs(h);
    check("R6 shadow not applied in current period", h, 256);
    period_highs(h);
    check("R6 shadow applied after rollover", h, 128);
    write(1'b0, 1'b1, 8'd10);
    period_highs(h);
    check("R6 new shadow deferred", h, 128);
    period_highs(h);
    check("R6 new shadow applied next period", h, 246);

    // Immediate active write (R5)
    setup(2'd3);
    write(1'b1, 1'b0, 8'd128);
    run_i = 1'b1;
    ticks(100);
    check("R3 low below compare", int'(pwm_o), 0);
    write(1'b1, 1'b0, 8'd50);
    check("R5 active write immediate", int'(pwm_o), 1);

    // Collision: rollover with both writes (R7)
    setup(2'd3);
    write(1'b1, 1'b1, 8'd200);
    write(1'b0, 1'b1, 8'd40);
    run_i = 1'b1;
    ticks(255);
    check("R3 high at top count", int'(pwm_o), 1);
    ovf_tick_i = 1'b1;
    wr_act_i   = 1'b1;
    wr_shd_i   = 1'b1;
    wr_data_i  = 8'd99;
    @(negedge clk_i);
    ovf_tick_i = 1'b0;
    wr_act_i   = 1'b0;
    wr_shd_i   = 1'b0;
    check("R7 low at count 0", int'(pwm_o), 0);
    ticks(40);
    check("R7 rollover copy wins over active write", int'(pwm_o), 1);
    ticks(216);
    ticks(98);
    check("R7 shadow took same-cycle write (count 98)", int'(pwm_o), 0);
    tick();
    check("R7 shadow took same-cycle write (count 99)", int'(pwm_o), 1);

    // Run gating (R4)
    setup(2'd3);
    write(1'b1, 1'b0, 8'd3);
    ticks(5);
    check("R4 timer holds while run low", int'(pwm_o), 0);
    run_i = 1'b1;
    ticks(3);
    check("R4 timer steps while run high", int'(pwm_o), 1);

    // Clock divider sources (R8)
    setup(2'd0);
    write(1'b1, 1'b1, 8'd64);
    run_i = 1'b1;
    repeat (20) @(negedge clk_i);
    clk_highs(1024, h);
    check("R8 divide-by-4 source high cycles", h, 768);
    setup(2'd1);
    write(1'b1, 1'b1, 8'd200);
    run_i = 1'b1;
    repeat (40) @(negedge clk_i);
    clk_highs(3072, h);
    check("R8 divide-by-12 source high cycles", h, 672);

    // External edge source (R9)
    setup(2'd2);
    write(1'b1, 1'b1, 8'd5);
    run_i = 1'b1;
    for (int e = 0; e < 4; e++) begin
      ext_tick_i = 1'b1;
      repeat (3) @(negedge clk_i);
      ext_tick_i = 1'b0;
      repeat (3) @(negedge clk_i);
    end
    repeat (5) @(negedge clk_i);
    check("R9 four edges give count 4", int'(pwm_o), 0);
    ext_tick_i = 1'b1;
    repeat (50) @(negedge clk_i);
    check("R9 fifth edge gives count 5", int'(pwm_o), 1);
    write(1'b1, 1'b0, 8'd6);
    check("R9 held level adds no tick", int'(pwm_o), 0);
    ext_tick_i = 1'b0;

    // Mode gating (R2)
    setup(2'd3);
    write(1'b1, 1'b0, 8'd200);
    check("R2 enabled output low at count 0", int'(pwm_o), 0);
    pwm_en_i = 1'b0;
    @(negedge clk_i);
    check("R2 output high with pwm enable clear", int'(pwm_o), 1);
    write(1'b1, 1'b1, 8'd200);
    pwm_en_i = 1'b1;
    cmp_en_i = 1'b0;
    @(negedge clk_i);
    check("R2 output high with compare enable clear", int'(pwm_o), 1);
    cmp_en_i = 1'b1;
    run_i    = 1'b1;
    @(negedge clk_i);
    period_highs(h);
    check("R2 writes while disabled ignored", h, 256);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule